// File: doc/BRIEF.md
# Mode-Dependent Effective Address Generator

This unit forms operand addresses and the next instruction address for a byte-addressed processor. A request carries a 4-bit base-register selector, a 4-bit index-register selector, a 12-bit unsigned displacement, a format flag and a one-bit addressing mode. The unit reads the selected entries of a local 16 x 32-bit general register file and adds the base value, the zero-extended displacement and, for indexed formats only, the index value. It discards carries out of bit 31. It then clears the top byte of the sum in the narrow mode, or only bit 31 in the wide mode. A selector value of zero always stands for "no component", whatever register 0 holds.

The same request also carries the current instruction address, the instruction length in bytes and a branch-taken flag. The unit adds the length to the instruction address and clips the result by mode. When the branch is taken, the computed operand address becomes the next instruction address. Lengths other than 2, 4 or 6 bytes raise an error flag, and in that case the instruction address is passed through unchanged. Results are registered and appear one cycle after the request strobe, marked by an output-valid pulse. The register file has one synchronous write port, which software-visible register updates use.

Top module: `agu_top`

## Requirements
- R1: The operand address is base + zero-extended displacement + index, taken modulo 2^32 (carries out of bit 31 are lost) before mode clipping.
- R2: With `mode31`=0 (narrow mode) the operand address and the continuation address have bits 31:24 equal to zero.
- R3: With `mode31`=1 (wide mode) the operand address and the continuation address have bit 31 equal to zero and keep bits 30:0.
- R4: A base selector of 0 adds nothing, even when register 0 holds a non-zero value.
- R5: An index selector of 0 adds nothing, even when register 0 holds a non-zero value.
- R6: The index value is added only when `fmt_indexed`=1; with `fmt_indexed`=0 the index selector has no effect.
- R7: With a legal length and `br_taken`=0, `next_ia` is `cur_ia` + `ilen`, clipped by mode as in R2/R3.
- R8: With a legal length and `br_taken`=1, `next_ia` equals the mode-clipped operand address of the same request.
- R9: An `ilen` value other than 2, 4 or 6 sets `len_err`=1 and makes `next_ia` equal to `cur_ia` unmodified, whether or not the branch is taken; legal lengths give `len_err`=0.
- R10: `ea_out`, `next_ia` and `len_err` update on the clock edge that samples `req_valid`=1, and `out_valid` is high for exactly that following cycle. Without a request, the outputs hold their values.
- R11: A register write (`wr_en`, `wr_sel`, `wr_data`) takes effect at the clock edge. A request in the same cycle that selects the register being written uses its old value.
- R12: Synchronous active-high `rst` clears all outputs and all sixteen registers to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register file write enable |
| wr_sel | input | 4 | Register number to write |
| wr_data | input | 32 | Write data |
| req_valid | input | 1 | Request strobe |
| mode31 | input | 1 | 1 = 31-bit addressing, 0 = 24-bit addressing |
| fmt_indexed | input | 1 | 1 = format permits an index component |
| base_sel | input | 4 | Base register selector, 0 = none |
| idx_sel | input | 4 | Index register selector, 0 = none |
| disp | input | 12 | Unsigned displacement |
| cur_ia | input | 32 | Current instruction address |
| ilen | input | 3 | Instruction length in bytes |
| br_taken | input | 1 | Branch condition met |
| out_valid | output | 1 | Results registered this cycle |
| ea_out | output | 32 | Operand address |
| next_ia | output | 32 | Next instruction address |
| len_err | output | 1 | Illegal instruction length |

## Verification
A register write and an address request that reads the same register can arrive in one cycle. The bench provokes this by writing a fresh value to a register while a request uses it as base. It expects the old value in the resulting address, then issues a second request and expects the new value. A branch with an illegal length is a second collision. The bench sends a taken branch with a bad length and expects the error flag with the unchanged instruction address, not the branch target.

// File: rtl/agu_pkg.sv
package agu_pkg;
    localparam int XLEN  = 32;
    localparam int NREG  = 16;
    localparam int RSELW = $clog2(NREG);
    localparam int DISPW = 12;
    localparam int ILENW = 3;
    localparam int NARROW_BITS = 24;

    typedef enum logic {
        AMODE_24 = 1'b0,
        AMODE_31 = 1'b1
    } amode_e;

    typedef struct packed {
        amode_e             mode;
        logic               fmt_rx;
        logic [RSELW-1:0]   bsel;
        logic [RSELW-1:0]   xsel;
        logic [DISPW-1:0]   disp;
    } ea_req_t;

    typedef struct packed {
        logic [XLEN-1:0] ea;
        logic [XLEN-1:0] nia;
        logic            bad_len;
    } agu_res_t;

    function automatic logic [XLEN-1:0] mode_clip(input logic [XLEN-1:0] a, input amode_e m);
        logic [XLEN-1:0] r;
        if (m == AMODE_31)
            r = {1'b0, a[XLEN-2:0]};
        else
            r = {{(XLEN-NARROW_BITS){1'b0}}, a[NARROW_BITS-1:0]};
        return r;
    endfunction

    function automatic logic length_legal(input logic [ILENW-1:0] l);
        return (l == ILENW'(2)) || (l == ILENW'(4)) || (l == ILENW'(6));
    endfunction
endpackage

// File: rtl/agu_regfile.sv
module agu_regfile
    import agu_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               we,
    input  logic [RSELW-1:0]   wsel,
    input  logic [XLEN-1:0]    wdata,
    input  logic [RSELW-1:0]   rsel_a,
    input  logic [RSELW-1:0]   rsel_b,
    output logic [XLEN-1:0]    rdata_a,
    output logic [XLEN-1:0]    rdata_b
);
    logic [XLEN-1:0] regs [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst)
                regs[g] <= '0;
            else if (we && (wsel == RSELW'(g)))
                regs[g] <= wdata;
        end
    end

    // Combinational reads: a write lands at the edge, so a same-cycle read sees the old word.
    assign rdata_a = regs[rsel_a];
    assign rdata_b = regs[rsel_b];
endmodule

// File: rtl/agu_ea_adder.sv
module agu_ea_adder
    import agu_pkg::*;
(
    input  ea_req_t          req,
    input  logic [XLEN-1:0]  base_val,
    input  logic [XLEN-1:0]  idx_val,
    output logic [XLEN-1:0]  ea
);
    logic [XLEN-1:0] base_term;
    logic [XLEN-1:0] idx_term;
    logic [XLEN-1:0] disp_term;
    logic [XLEN-1:0] raw_sum;

    always_comb begin
        base_term = (req.bsel == '0) ? '0 : base_val;
        idx_term  = (req.xsel == '0 || !req.fmt_rx) ? '0 : idx_val;
        disp_term = {{(XLEN-DISPW){1'b0}}, req.disp};
        raw_sum   = base_term + disp_term + idx_term;
        ea        = mode_clip(raw_sum, req.mode);
    end
endmodule

// File: rtl/agu_seq.sv
module agu_seq
    import agu_pkg::*;
(
    input  amode_e            mode,
    input  logic [XLEN-1:0]   ia,
    input  logic [ILENW-1:0]  len,
    input  logic              taken,
    input  logic [XLEN-1:0]   target,
    output logic [XLEN-1:0]   nia,
    output logic              bad_len
);
    logic [XLEN-1:0] cont;

    always_comb begin
        cont    = mode_clip(ia + {{(XLEN-ILENW){1'b0}}, len}, mode);
        bad_len = !length_legal(len);
        if (bad_len)
            nia = ia;
        else if (taken)
            nia = target;
        else
            nia = cont;
    end
endmodule

// File: rtl/agu_top.sv
module agu_top
    import agu_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [3:0]   wr_sel,
    input  logic [31:0]  wr_data,
    input  logic         req_valid,
    input  logic         mode31,
    input  logic         fmt_indexed,
    input  logic [3:0]   base_sel,
    input  logic [3:0]   idx_sel,
    input  logic [11:0]  disp,
    input  logic [31:0]  cur_ia,
    input  logic [2:0]   ilen,
    input  logic         br_taken,
    output logic         out_valid,
    output logic [31:0]  ea_out,
    output logic [31:0]  next_ia,
    output logic         len_err
);
    ea_req_t         req;
    logic [XLEN-1:0] rd_base;
    logic [XLEN-1:0] rd_idx;
    agu_res_t        comb_res;
    agu_res_t        res_q;
    logic            vld_q;

    always_comb begin
        req.mode   = amode_e'(mode31);
        req.fmt_rx = fmt_indexed;
        req.bsel   = base_sel;
        req.xsel   = idx_sel;
        req.disp   = disp;
    end

    agu_regfile u_rf (
        .clk     (clk),
        .rst     (rst),
        .we      (wr_en),
        .wsel    (wr_sel),
        .wdata   (wr_data),
        .rsel_a  (base_sel),
        .rsel_b  (idx_sel),
        .rdata_a (rd_base),
        .rdata_b (rd_idx)
    );

    agu_ea_adder u_add (
        .req      (req),
        .base_val (rd_base),
        .idx_val  (rd_idx),
        .ea       (comb_res.ea)
    );

    agu_seq u_seq (
        .mode    (req.mode),
        .ia      (cur_ia),
        .len     (ilen),
        .taken   (br_taken),
        .target  (comb_res.ea),
        .nia     (comb_res.nia),
        .bad_len (comb_res.bad_len)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
            vld_q <= 1'b0;
        end else begin
            vld_q <= req_valid;
            if (req_valid)
                res_q <= comb_res;
        end
    end

    assign out_valid = vld_q;
    assign ea_out    = res_q.ea;
    assign next_ia   = res_q.nia;
    assign len_err   = res_q.bad_len;
endmodule

// File: rtl/agu_chk.sv
module agu_chk (
    input logic         clk,
    input logic         rst,
    input logic         req_valid,
    input logic         mode31,
    input logic [31:0]  cur_ia,
    input logic [2:0]   ilen,
    input logic         out_valid,
    input logic [31:0]  ea_out,
    input logic [31:0]  next_ia,
    input logic         len_err
);
    logic legal;
    assign legal = (ilen == 3'd2) || (ilen == 3'd4) || (ilen == 3'd6);

    assert_valid_follows_R10: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> out_valid);
    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!out_valid && $stable(ea_out) && $stable(next_ia) && $stable(len_err)));
    assert_narrow_top_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !mode31) |=> (ea_out[31:24] == 8'h00));
    assert_wide_msb_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && mode31) |=> (ea_out[31] == 1'b0));
    assert_bad_len_holds_ia_R9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !legal) |=> (len_err && next_ia == $past(cur_ia)));
    assert_good_len_clear_R9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && legal) |=> !len_err);
endmodule

bind agu_top agu_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .mode31    (mode31),
    .cur_ia    (cur_ia),
    .ilen      (ilen),
    .out_valid (out_valid),
    .ea_out    (ea_out),
    .next_ia   (next_ia),
    .len_err   (len_err)
);

// File: tb/sim_agu_top.sv
module sim_agu_top;
    logic         clk = 1'b0;
    logic         rst;
    logic         wr_en;
    logic [3:0]   wr_sel;
    logic [31:0]  wr_data;
    logic         req_valid;
    logic         mode31;
    logic         fmt_indexed;
    logic [3:0]   base_sel;
    logic [3:0]   idx_sel;
    logic [11:0]  disp;
    logic [31:0]  cur_ia;
    logic [2:0]   ilen;
    logic         br_taken;
    logic         out_valid;
    logic [31:0]  ea_out;
    logic [31:0]  next_ia;
    logic         len_err;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    agu_top u0 (.*);

    typedef struct packed {
        logic        m31;
        logic        fx;
        logic [3:0]  b;
        logic [3:0]  x;
        logic [11:0] d;
        logic [31:0] ia;
        logic [2:0]  len;
        logic        br;
        logic [31:0] e_ea;
        logic [31:0] e_nia;
        logic        e_err;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{1'b1,1'b1,4'd1,4'd2,12'h004,32'h0000_0100,3'd4,1'b0,32'h0000_1014,32'h0000_0104,1'b0}, // R1
        '{1'b0,1'b1,4'd5,4'd2,12'h010,32'h00FF_FFFE,3'd2,1'b0,32'h0000_0010,32'h0000_0000,1'b0}, // R2 R7
        '{1'b1,1'b1,4'd5,4'd2,12'h010,32'h7FFF_FFFE,3'd4,1'b0,32'h0100_0010,32'h0000_0002,1'b0}, // R3 R7
        '{1'b1,1'b1,4'd3,4'd3,12'h002,32'h0000_0200,3'd6,1'b0,32'h0000_0000,32'h0000_0206,1'b0}, // R1 carry
        '{1'b1,1'b1,4'd0,4'd1,12'hFFF,32'h0000_0000,3'd2,1'b0,32'h0000_1FFF,32'h0000_0002,1'b0}, // R4
        '{1'b1,1'b1,4'd1,4'd0,12'h000,32'h0000_0010,3'd4,1'b0,32'h0000_1000,32'h0000_0014,1'b0}, // R5
        '{1'b1,1'b0,4'd1,4'd2,12'h020,32'h0000_0040,3'd2,1'b0,32'h0000_1020,32'h0000_0042,1'b0}, // R6
        '{1'b1,1'b1,4'd4,4'd2,12'hFFF,32'h0000_0300,3'd4,1'b1,32'h0000_0F0F,32'h0000_0F0F,1'b0}, // R8
        '{1'b0,1'b1,4'd1,4'd0,12'h008,32'h0000_0300,3'd6,1'b1,32'h0000_1008,32'h0000_1008,1'b0}, // R8
        '{1'b1,1'b1,4'd1,4'd0,12'h000,32'h0000_0500,3'd3,1'b0,32'h0000_1000,32'h0000_0500,1'b1}, // R9
        '{1'b1,1'b1,4'd1,4'd0,12'h000,32'h0000_0600,3'd0,1'b1,32'h0000_1000,32'h0000_0600,1'b1}, // R9 branch
        '{1'b0,1'b1,4'd1,4'd0,12'h000,32'h0765_4321,3'd7,1'b0,32'h0000_1000,32'h0765_4321,1'b1}  // R9 narrow
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [3:0] s, input logic [31:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = s; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic issue(input vec_t v);
        @(negedge clk);
        req_valid = 1'b1; mode31 = v.m31; fmt_indexed = v.fx;
        base_sel = v.b; idx_sel = v.x; disp = v.d;
        cur_ia = v.ia; ilen = v.len; br_taken = v.br;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        #(4 * 200000);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        vec_t t;
        rst = 1'b1; wr_en = 1'b0; wr_sel = '0; wr_data = '0;
        req_valid = 1'b0; mode31 = 1'b1; fmt_indexed = 1'b1;
        base_sel = '0; idx_sel = '0; disp = '0; cur_ia = '0; ilen = 3'd2; br_taken = 1'b0;
        repeat (3) @(negedge clk);
        // R12: reset state
        check("R12 out_valid", {31'b0, out_valid}, 32'h0);
        check("R12 ea_out", ea_out, 32'h0);
        check("R12 next_ia", next_ia, 32'h0);
        check("R12 len_err", {31'b0, len_err}, 32'h0);
        rst = 1'b0;

        wr_reg(4'd0, 32'h1234_5678);
        wr_reg(4'd1, 32'h0000_1000);
        wr_reg(4'd2, 32'h0000_0010);
        wr_reg(4'd3, 32'hFFFF_FFFF);
        wr_reg(4'd4, 32'h7FFF_FF00);
        wr_reg(4'd5, 32'h80FF_FFF0);

        for (int i = 0; i < NV; i++) begin
            issue(VECS[i]);
            check($sformatf("R10 valid v%0d", i), {31'b0, out_valid}, 32'h1);
            check($sformatf("R1-vector ea v%0d", i), ea_out, VECS[i].e_ea);
            check($sformatf("R7 next_ia v%0d", i), next_ia, VECS[i].e_nia);
            check($sformatf("R9 len_err v%0d", i), {31'b0, len_err}, {31'b0, VECS[i].e_err});
        end

        // R10: idle cycle holds outputs while inputs move
        @(negedge clk);
        base_sel = 4'd3; disp = 12'h777; cur_ia = 32'hDEAD_0000; ilen = 3'd2;
        @(negedge clk);
        check("R10 idle valid", {31'b0, out_valid}, 32'h0);
        check("R10 hold ea", ea_out, 32'h0000_1000);
        check("R10 hold nia", next_ia, 32'h0765_4321);

        // R11: write r6 in the same cycle a request reads it
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 4'd6; wr_data = 32'h0000_AAAA;
        req_valid = 1'b1; mode31 = 1'b1; fmt_indexed = 1'b1;
        base_sel = 4'd6; idx_sel = 4'd0; disp = 12'h010; cur_ia = 32'h0; ilen = 3'd2; br_taken = 1'b0;
        @(negedge clk);
        wr_en = 1'b0; req_valid = 1'b0;
        check("R11 old value", ea_out, 32'h0000_0010);
        t = '{1'b1,1'b1,4'd6,4'd0,12'h010,32'h0,3'd2,1'b0,32'h0,32'h0,1'b0};
        issue(t);
        check("R11 new value", ea_out, 32'h0000_AABA);

        // R12: reset again clears outputs and registers
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R12 ea after rst", ea_out, 32'h0);
        check("R12 valid after rst", {31'b0, out_valid}, 32'h0);
        rst = 1'b0;
        issue(t);
        check("R12 reg cleared", ea_out, 32'h0000_0010);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule